// File: doc/BRIEF.md
# Fan PWM Duty Controller with Driven-Duty Readback

This block drives one fan PWM pin from an 8-bit duty value that software writes over a small register bus. Software writes go into a pending register. The duty actually on the pin sits in a second register, and that second register takes the pending value only when a new PWM period begins. A read of the duty address returns this driven value and never the last value written. Software can therefore see when a change has actually reached the fan.

The PWM period is 256 ticks, and each tick lasts `PRESCALE` clock cycles. The pin is high while the tick position is below the driven duty, so 00h gives 0%, 40h gives 25% and 80h gives 50%. FFh keeps the pin high for the whole period. A spin-up request forces full drive for a programmable number of period boundaries. While spin-up lasts, the duty readback shows zero. After spin-up ends, the pin returns to the driven duty at a period boundary.

Top module: `fan_duty_ctrl`

## Requirements
- R1: When spin-up is not active and the driven duty D is below FFh, the pin is high for exactly D*PRESCALE clock cycles in each period of 256*PRESCALE cycles, and it is high at the start of the period.
- R2: A driven duty of FFh holds the pin high for every cycle of the period.
- R3: A write to address 0 changes only the pending duty, and a read of address 0 keeps returning the previous driven duty until the next period boundary.
- R4: At each period boundary the driven duty loads the pending value, so a written value reads back after a delay of at least 1 and at most 256*PRESCALE cycles.
- R5: A write to address 0 in the same cycle as a period boundary misses that boundary: the old pending value is loaded, and the new value is loaded at the following boundary.
- R6: A pulse on spin_req while spin-up is idle makes the pin high from the next cycle on. While spin-up is active, a read of address 0 returns 00h.
- R7: Spin-up ends at the N-th period boundary after it starts, where N is the value at address 1 and a value of 0 counts as 1. At that boundary the pin returns to the duty loaded there.
- R8: A spin_req pulse while spin-up is active is ignored and does not lengthen it.
- R9: Address 1 holds the 8-bit spin-up length and can be read and written. Address 2 reads 00h. Writes to addresses 2 and 3 change neither stored register.
- R10: Reset clears the pending duty, the driven duty and the period counter, and sets the spin-up length to 2. The pin stays low until a nonzero value has been written and a period boundary has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (0 duty, 1 spin-up length) |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spin_req | input | 1 | Spin-up request, acted on when idle |
| pwm_out | output | 1 | Fan PWM drive |

## Verification
Two events can fall in the same clock edge. A software write to the duty register can land on the edge where the period boundary loads the driven duty. The end of spin-up also always falls on a boundary, and on that edge the driven duty is loaded as well. The bench follows its own model of the tick position and places a duty write exactly on a boundary edge. It then requires that the readback show the old pending value first and the new one only one period later. For spin-up, it counts the boundaries that pass before the readback leaves zero, and it requires that the pin follow the duty loaded on the ending edge. A behavioural model checks the pin and the read data on every clock.

// File: rtl/fan_duty_pkg.sv
package fan_duty_pkg;

    localparam int DUTY_W = 8;
    localparam int ADDR_W = 2;

    typedef logic [DUTY_W-1:0] duty_t;

    localparam duty_t DUTY_FULL = '1;

    typedef enum logic [ADDR_W-1:0] {
        REG_DUTY = 2'd0,
        REG_SPIN = 2'd1
    } reg_addr_e;

    typedef struct packed {
        duty_t pend;
        duty_t cur;
    } duty_pair_t;

    function automatic logic pwm_level(duty_t pos, duty_t duty);
        return (duty == DUTY_FULL) || (pos < duty);
    endfunction

endpackage

// File: rtl/fan_period_timer.sv
module fan_period_timer
    import fan_duty_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic  clk,
    input  logic  rst,
    output duty_t pos,
    output logic  boundary
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic tick;

    generate
        if (PRESCALE == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] pre;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pre <= '0;
                end else if (pre == PW'(PRESCALE - 1)) begin
                    pre <= '0;
                end else begin
                    pre <= pre + 1'b1;
                end
            end
            assign tick = (pre == PW'(PRESCALE - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (tick) begin
            pos <= pos + 1'b1;
        end
    end

    assign boundary = tick && (pos == DUTY_FULL);

    // R1: every period begins at position zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (pos == '0));

endmodule

// File: rtl/fan_spinup_ctrl.sv
module fan_spinup_ctrl
    import fan_duty_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  spin_req,
    input  logic  boundary,
    input  duty_t spin_len,
    output logic  active
);

    duty_t left;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            left   <= '0;
        end else if (active) begin
            if (boundary) begin
                if (left <= duty_t'(1)) begin
                    active <= 1'b0;
                    left   <= '0;
                end else begin
                    left <= left - 1'b1;
                end
            end
        end else if (spin_req) begin
            active <= 1'b1;
            left   <= (spin_len == '0) ? duty_t'(1) : spin_len;
        end
    end

    p_start_r6: assert property (@(posedge clk) disable iff (rst)
        (!active && spin_req) |=> active);

    p_end_at_bnd_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(boundary));

    p_req_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (active && !boundary) |=> (active && $stable(left)));

endmodule

// File: rtl/fan_duty_regs.sv
module fan_duty_regs
    import fan_duty_pkg::*;
#(
    parameter int SPIN_RESET = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  duty_t             wdata,
    input  logic              boundary,
    input  logic              spin_active,
    output duty_t             cur,
    output duty_t             spin_len,
    output duty_t             rdata
);

    duty_pair_t d;

    always_ff @(posedge clk) begin
        if (rst) begin
            d        <= '0;
            spin_len <= duty_t'(SPIN_RESET);
        end else begin
            if (wr && addr == REG_DUTY) begin
                d.pend <= wdata;
            end
            if (wr && addr == REG_SPIN) begin
                spin_len <= wdata;
            end
            if (boundary) begin
                d.cur <= d.pend;
            end
        end
    end

    assign cur = d.cur;

    always_comb begin
        case (addr)
            REG_DUTY: rdata = spin_active ? '0 : d.cur;
            REG_SPIN: rdata = spin_len;
            default:  rdata = '0;
        endcase
    end

    p_cur_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(d.cur));

    p_cur_load_r4: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (d.cur == $past(d.pend)));

    p_rd_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (spin_active && addr == REG_DUTY) |-> (rdata == '0));

endmodule

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl
    import fan_duty_pkg::*;
#(
    parameter int PRESCALE   = 4,
    parameter int SPIN_RESET = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DUTY_W-1:0] bus_wdata,
    output logic [DUTY_W-1:0] bus_rdata,
    input  logic              spin_req,
    output logic              pwm_out
);

    duty_t pos;
    duty_t cur;
    duty_t spin_len;
    logic  boundary;
    logic  spin_active;

    fan_period_timer #(.PRESCALE(PRESCALE)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .pos      (pos),
        .boundary (boundary)
    );

    fan_spinup_ctrl u_spin (
        .clk      (clk),
        .rst      (rst),
        .spin_req (spin_req),
        .boundary (boundary),
        .spin_len (spin_len),
        .active   (spin_active)
    );

    fan_duty_regs #(.SPIN_RESET(SPIN_RESET)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .addr        (bus_addr),
        .wr          (bus_wr),
        .wdata       (bus_wdata),
        .boundary    (boundary),
        .spin_active (spin_active),
        .cur         (cur),
        .spin_len    (spin_len),
        .rdata       (bus_rdata)
    );

    assign pwm_out = spin_active | pwm_level(pos, cur);

    p_full_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!spin_active && cur == DUTY_FULL) |-> pwm_out);

    p_zero_low_r10: assert property (@(posedge clk) disable iff (rst)
        (!spin_active && cur == '0) |-> !pwm_out);

    p_spin_high_r6: assert property (@(posedge clk) disable iff (rst)
        spin_active |-> pwm_out);

endmodule

// File: tb/fan_duty_ctrl_bench.sv
`timescale 1ns/1ps
module fan_duty_ctrl_bench;

    localparam int P      = 4;
    localparam int PERIOD = 256 * P;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       spin_req = 1'b0;
    logic       pwm_out;

    always #2 clk = ~clk;

    fan_duty_ctrl #(.PRESCALE(P), .SPIN_RESET(2)) u_fan_duty_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spin_req  (spin_req),
        .pwm_out   (pwm_out)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // behavioural reference state
    int m_pre, m_pos, m_pend, m_cur, m_len, m_left, m_bnds;
    bit m_spin;

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_pos = 0; m_pend = 0; m_cur = 0; m_len = 2;
            m_left = 0; m_spin = 0; m_bnds = 0;
        end else begin
            bit bnd;
            int old_pend, old_len;
            bnd = (m_pre == P - 1) && (m_pos == 255);
            old_pend = m_pend;
            old_len = m_len;
            if (bus_wr && bus_addr == 2'd0) m_pend = bus_wdata;
            if (bus_wr && bus_addr == 2'd1) m_len = bus_wdata;
            if (m_spin) begin
                if (bnd) begin
                    if (m_left <= 1) m_spin = 0;
                    else m_left = m_left - 1;
                end
            end else if (spin_req) begin
                m_spin = 1;
                m_left = (old_len == 0) ? 1 : old_len;
            end
            if (bnd) begin
                m_cur = old_pend;
                m_bnds = m_bnds + 1;
            end
            if (m_pre == P - 1) begin
                m_pre = 0;
                m_pos = (m_pos + 1) % 256;
            end else begin
                m_pre = m_pre + 1;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            int e_pwm, e_rd;
            e_pwm = (m_spin || m_cur == 255 || m_pos < m_cur) ? 1 : 0;
            case (bus_addr)
                2'd0:    e_rd = m_spin ? 0 : m_cur;
                2'd1:    e_rd = m_len;
                default: e_rd = 0;
            endcase
            check("model pwm R1 R2 R6 R7", int'(pwm_out), e_pwm);
            check("model rdata R3 R4 R6 R9", int'(bus_rdata), e_rd);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        cyc(1);
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic read_at(logic [1:0] a, string tag, int exp);
        bus_addr = a;
        @(negedge clk);
        check(tag, int'(bus_rdata), exp);
        cyc(1);
        bus_addr = 2'd0;
    endtask

    // leaves the bench just after an edge so that the next edge is a boundary
    task automatic until_bnd_next();
        while (!((m_pre == P - 1) && (m_pos == 255))) cyc(1);
    endtask

    task automatic count_high(output int n);
        n = 0;
        repeat (PERIOD) begin
            @(negedge clk);
            if (pwm_out) n++;
        end
        #3;
    endtask

    task automatic spin_len_check(string tag, int exp_bnds, bit repulse);
        int b0, guard;
        spin_req = 1'b1;
        cyc(1);
        spin_req = 1'b0;
        b0 = m_bnds;
        @(negedge clk);
        check({tag, " pin forced"}, int'(pwm_out), 1);
        check({tag, " readback zero"}, int'(bus_rdata), 0);
        if (repulse) begin
            cyc(300);
            spin_req = 1'b1;   // R8: ignored
            cyc(1);
            spin_req = 1'b0;
        end
        guard = 0;
        while (bus_rdata == 8'd0 && guard < 20 * PERIOD) begin
            @(negedge clk);
            guard++;
        end
        check({tag, " boundaries"}, m_bnds - b0, exp_bnds);
        cyc(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, lag;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        check("R10 pin low after reset", int'(pwm_out), 0);
        check("R10 duty readback zero", int'(bus_rdata), 0);
        cyc(1);
        read_at(2'd1, "R10 spin length default", 2);

        until_bnd_next();
        cyc(1);
        count_high(n);
        check("R10 pin low with nothing written", n, 0);

        // R3 / R4: write then measure lag
        cyc(100);
        bus_write(2'd0, 8'h40);
        @(negedge clk);
        check("R3 readback unchanged after write", int'(bus_rdata), 0);
        lag = 1;
        while (bus_rdata != 8'h40 && lag < 3 * PERIOD) begin
            @(negedge clk);
            lag++;
        end
        check("R4 lag within one period", (lag >= 1 && lag <= PERIOD) ? 1 : 0, 1);
        cyc(1);

        // R1: 25% duty
        until_bnd_next();
        cyc(1);
        count_high(n);
        check("R1 high cycles for 40h", n, 64 * P);

        // R2: full
        bus_write(2'd0, 8'hFF);
        until_bnd_next();
        cyc(1);
        count_high(n);
        check("R2 high cycles for FFh", n, PERIOD);

        // R1: 50% duty
        bus_write(2'd0, 8'h80);
        until_bnd_next();
        cyc(1);
        count_high(n);
        check("R1 high cycles for 80h", n, 128 * P);

        // R5: write on the boundary edge
        bus_write(2'd0, 8'h30);
        until_bnd_next();
        bus_write(2'd0, 8'h20);
        @(negedge clk);
        check("R5 old pending loaded on boundary", int'(bus_rdata), 8'h30);
        cyc(1);
        until_bnd_next();
        cyc(1);
        @(negedge clk);
        check("R5 new value at following boundary", int'(bus_rdata), 8'h20);
        cyc(1);

        // R9: register map
        bus_write(2'd1, 8'd3);
        read_at(2'd1, "R9 spin length readback", 3);
        read_at(2'd2, "R9 unused address reads zero", 0);
        bus_write(2'd3, 8'h55);
        bus_write(2'd2, 8'h66);
        read_at(2'd1, "R9 spin length kept", 3);
        until_bnd_next();
        cyc(2);
        read_at(2'd0, "R9 duty kept", 8'h20);

        // R6 R7 R8: spin-up
        cyc(57);
        spin_len_check("R7 length 3 with R8 re-request", 3, 1'b1);
        @(negedge clk);
        check("R7 readback after spin", int'(bus_rdata), 8'h20);
        cyc(1);
        bus_write(2'd1, 8'd0);
        cyc(211);
        spin_len_check("R7 length 0 as one R6", 1, 1'b0);

        // R7: spin ending with a new duty loaded on the same edge
        bus_write(2'd1, 8'd1);
        cyc(90);
        spin_req = 1'b1;
        cyc(1);
        spin_req = 1'b0;
        bus_write(2'd0, 8'h10);
        until_bnd_next();
        cyc(1);
        @(negedge clk);
        check("R7 duty loaded as spin ends", int'(bus_rdata), 8'h10);
        cyc(1);
        count_high(n);
        check("R7 pin follows new duty", n, 16 * P);

        cyc(5);
        finish_run();
    end

endmodule